// File: doc/BRIEF.md
# Power-On and Pin Reset Sequencer

This block produces the single internal reset of a small microcontroller core. Two sources feed it. The first is an active-low reset pin from the board. The second is an on-chip power-on path, and a configuration bit turns that path on or off.

When the power-on path is on, the supply-good input decides what happens. While it is low, the internal reset is held and a 12-bit down-counter is loaded with 0xFFF. When supply-good goes high, the counter counts down once per clock. The reset is released on the clock after the counter has passed zero, which gives a hold of 4096 cycles. After that release the power-on path stays quiet for as long as the supply remains good. If the supply drops and comes back, the whole sequence starts again.

The pin goes through a two-flop synchronizer before it is used. A low on the pin is only accepted after it has lasted one instruction cycle, which is ten clocks. An accepted pin reset holds the internal reset until the pin is released. It also sends a one-clock wake strobe that takes the core out of its halted state. Both sources put the core into the same reset. A source flag records whether the last reset was cold (from the power-on path) or warm (from the pin), so that downstream registers can choose their start-up values.

Top module: `boot_reset_seq`

## Requirements
- R1: While supply_ok is low, cold_reset is 1. In the same state core_rst is 1 if por_enable is 1, and 0 if por_enable is 0.
- R2: With por_enable at 1, core_rst stays 1 through the first 4095 rising clock edges after supply_ok rises. It goes to 0 at the 4096th edge.
- R3: Once the power-on hold has ended, core_rst stays 0 for as long as supply_ok stays high and ext_rst_n stays high.
- R4: With por_enable at 0, a rise of supply_ok does not assert core_rst. Only the pin can reset the core.
- R5: A low on ext_rst_n that is sampled on 10 consecutive clock edges asserts core_rst at the 12th edge after the first low sample. A low that lasts 9 edges or fewer has no effect on core_rst.
- R6: A pin reset that has been accepted holds core_rst at 1 while the pin stays low. After the pin is sampled high, core_rst stays 1 for two more edges and returns to 0 at the third edge.
- R7: cold_reset is 1 after a power-on reset. It becomes 0 when a pin reset is accepted outside the power-on hold. Between resets it keeps its value, and it never rises while supply_ok stays high.
- R8: halt_wake is high for exactly one clock, on the same edge at which a pin reset is accepted.
- R9: If supply_ok falls in the middle of the power-on hold and then rises again, the full 4096-edge hold restarts from the new rise.
- R10: A pin reset that is accepted during the power-on hold keeps cold_reset at 1 and does not shorten the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| supply_ok | input | 1 | Digital supply-good level. Low clears the block asynchronously. |
| por_enable | input | 1 | Configuration bit that turns on the power-on reset path |
| ext_rst_n | input | 1 | Asynchronous active-low reset pin |
| core_rst | output | 1 | Internal reset, active high |
| cold_reset | output | 1 | 1 = last reset came from the power-on path, 0 = last reset came from the pin |
| halt_wake | output | 1 | One-clock strobe when a pin reset is accepted |

## Verification
The hardest case to reach is the edge of the pin qualifier. A pulse of exactly nine edges must be rejected and a pulse of ten must be accepted. Because of the synchronizer, the two outcomes differ by a single sample that only shows up two clocks later. The bench drives pin pulses whose widths are drawn from a seeded random range around that threshold. It also drives a directed ten-edge pulse and checks core_rst on the exact edge where it should rise. A second hard case is a pin reset that arrives inside the 4096-cycle power-on hold. The bench brings it about by driving the pin pulse a fixed number of cycles after the supply rises, and then checks that both the hold and the cold flag are left unchanged.

// File: rtl/brs_pkg.sv
package brs_pkg;
   typedef enum logic {
      SRC_WARM = 1'b0,
      SRC_COLD = 1'b1
   } rst_src_e;

   localparam int unsigned DEF_TIMER_W    = 12;
   localparam int unsigned DEF_QUAL       = 10;
   localparam int unsigned DEF_SYNC       = 2;
endpackage

// File: rtl/brs_pin_sync.sv
module brs_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_n,
   output logic pin_sync_n
);
   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q <= 1'b1;
            else         q <= pin_n;
         end
         assign pin_sync_n = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q <= '1;
            else         q <= {q[STAGES-2:0], pin_n};
         end
         assign pin_sync_n = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/brs_pin_qual.sv
module brs_pin_qual #(
   parameter int unsigned QUAL = 10
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_sync_n,
   output logic held,
   output logic accept,
   output logic strobe
);
   localparam int unsigned W = (QUAL < 2) ? 1 : $clog2(QUAL + 1);
   localparam logic [W-1:0] LAST = W'(QUAL - 1);

   logic [W-1:0] run_len;

   assign accept = !pin_sync_n && !held && (run_len == LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_len <= '0;
         held    <= 1'b0;
         strobe  <= 1'b0;
      end else begin
         strobe <= accept;
         if (pin_sync_n) begin
            run_len <= '0;
            held    <= 1'b0;
         end else if (accept) begin
            held <= 1'b1;
         end else if (!held) begin
            run_len <= run_len + 1'b1;
         end
      end
   end
endmodule

// File: rtl/brs_por_timer.sv
module brs_por_timer #(
   parameter int unsigned TIMER_W = 12,
   parameter int unsigned PRESET  = 4095
) (
   input  logic clk,
   input  logic arst_n,
   input  logic enable,
   output logic por_req
);
   localparam logic [TIMER_W-1:0] LOAD = TIMER_W'(PRESET);

   logic [TIMER_W-1:0] remain;
   logic               busy;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         remain <= LOAD;
         busy   <= 1'b1;
      end else if (busy) begin
         if (!enable || remain == '0) busy <= 1'b0;
         else                         remain <= remain - 1'b1;
      end
   end

   assign por_req = busy && enable;
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
   import brs_pkg::*;
#(
   parameter int unsigned TIMER_W     = DEF_TIMER_W,
   parameter int unsigned POR_PRESET  = (1 << DEF_TIMER_W) - 1,
   parameter int unsigned QUAL_CYCLES = DEF_QUAL,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic clk,
   input  logic supply_ok,
   input  logic por_enable,
   input  logic ext_rst_n,
   output logic core_rst,
   output logic cold_reset,
   output logic halt_wake
);
   generate
      if (POR_PRESET >= (1 << TIMER_W)) begin : g_bad_preset
         $error("POR_PRESET does not fit in TIMER_W bits");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("QUAL_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic     pin_sync_n;
   logic     pin_held;
   logic     pin_accept;
   logic     por_req;
   rst_src_e src_q;

   brs_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .arst_n     (supply_ok),
      .pin_n      (ext_rst_n),
      .pin_sync_n (pin_sync_n)
   );

   brs_pin_qual #(.QUAL(QUAL_CYCLES)) i_qual (
      .clk        (clk),
      .arst_n     (supply_ok),
      .pin_sync_n (pin_sync_n),
      .held       (pin_held),
      .accept     (pin_accept),
      .strobe     (halt_wake)
   );

   brs_por_timer #(.TIMER_W(TIMER_W), .PRESET(POR_PRESET)) i_por (
      .clk     (clk),
      .arst_n  (supply_ok),
      .enable  (por_enable),
      .por_req (por_req)
   );

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok)      src_q <= SRC_COLD;
      else if (por_req)    src_q <= SRC_COLD;
      else if (pin_accept) src_q <= SRC_WARM;
   end

   assign core_rst   = por_req || pin_held;
   assign cold_reset = (src_q == SRC_COLD);
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
   parameter int unsigned POR_CYCLES = 4096
) (
   input logic clk,
   input logic supply_ok,
   input logic por_enable,
   input logic ext_rst_n,
   input logic core_rst,
   input logic cold_reset,
   input logic halt_wake
);
   localparam int unsigned CW = $clog2(POR_CYCLES + 1);
   localparam logic [CW-1:0] CMAX = CW'(POR_CYCLES);

   logic [CW-1:0] since_up;
   logic          en_kept;

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) begin
         since_up <= '0;
         en_kept  <= 1'b1;
      end else begin
         if (since_up != CMAX) since_up <= since_up + 1'b1;
         en_kept <= en_kept && por_enable;
      end
   end

   // R2: reset held across the whole power-on window
   assert_por_hold_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      (en_kept && por_enable && since_up < CMAX) |-> core_rst);

   // R3: released core stays released while the pin is idle
   assert_no_rereset_R3: assert property (@(posedge clk) disable iff (!supply_ok)
      (!core_rst && ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2)) |=> !core_rst);

   // R4: with the power-on path off, only the pin resets
   assert_pin_only_R4: assert property (@(posedge clk) disable iff (!supply_ok)
      (since_up > 2 && !por_enable && !$past(por_enable) && ext_rst_n
       && $past(ext_rst_n) && $past(ext_rst_n, 2)) |=> !core_rst);

   // R7: the cold flag drops only together with a pin acceptance
   assert_warm_on_accept_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      $fell(cold_reset) |-> halt_wake);

   // R7: the cold flag never rises while the supply is good
   assert_cold_no_rise_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      !$rose(cold_reset));

   // R8: wake strobe is a single cycle and coincides with reset
   assert_wake_single_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      halt_wake |=> !halt_wake);

   assert_wake_in_reset_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      halt_wake |-> core_rst);
endmodule

bind boot_reset_seq brs_checker #(.POR_CYCLES(POR_PRESET + 1)) i_brs_checker (
   .clk        (clk),
   .supply_ok  (supply_ok),
   .por_enable (por_enable),
   .ext_rst_n  (ext_rst_n),
   .core_rst   (core_rst),
   .cold_reset (cold_reset),
   .halt_wake  (halt_wake)
);

// File: tb/test_boot_reset_seq.sv
module test_boot_reset_seq;
   localparam int QUAL = 10;
   localparam int HOLD = 4096;

   logic clk = 1'b0;
   logic supply_ok = 1'b0;
   logic por_enable = 1'b1;
   logic ext_rst_n = 1'b1;
   logic core_rst, cold_reset, halt_wake;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   boot_reset_seq i_boot_reset_seq (
      .clk        (clk),
      .supply_ok  (supply_ok),
      .por_enable (por_enable),
      .ext_rst_n  (ext_rst_n),
      .core_rst   (core_rst),
      .cold_reset (cold_reset),
      .halt_wake  (halt_wake)
   );

   function automatic bit exp_accept(int w);
      return w >= QUAL;
   endfunction

   task automatic chk(input int act, input int exp, input string req);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic power_down(input logic en, input int low_cycles);
      supply_ok  = 1'b0;
      por_enable = en;
      step(low_cycles);
   endtask

   task automatic pulse(input int w, output int saw, output int wakes);
      saw = 0;
      wakes = 0;
      ext_rst_n = 1'b0;
      for (int i = 0; i < w + 8; i++) begin
         if (i == w) ext_rst_n = 1'b1;
         step(1);
         if (core_rst) saw++;
         if (halt_wake) wakes++;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=0", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int saw, wakes, hi_cnt;
      int unsigned seed;
      logic prev_cold;
      seed = $urandom(32'd20240611);
      @(negedge clk);

      // R1 reset state with power-on path on
      power_down(1'b1, 4);
      chk(core_rst, 1, "R1 core_rst in supply loss");
      chk(cold_reset, 1, "R1 cold_reset in supply loss");
      chk(halt_wake, 0, "R1 halt_wake idle");

      // R2 exact hold length
      supply_ok = 1'b1;
      step(HOLD - 1);
      chk(core_rst, 1, "R2 still held at edge 4095");
      step(1);
      chk(core_rst, 0, "R2 released at edge 4096");
      chk(cold_reset, 1, "R7 cold after power-on");

      // R3 no spontaneous reset
      hi_cnt = 0;
      for (int i = 0; i < 3000; i++) begin
         step(1);
         if (core_rst) hi_cnt++;
      end
      chk(hi_cnt, 0, "R3 no reset while supply good");

      // R5 exact acceptance edge, R6 release timing
      ext_rst_n = 1'b0;
      step(11);
      chk(core_rst, 0, "R5 not yet accepted at edge 11");
      step(1);
      chk(core_rst, 1, "R5 accepted at edge 12");
      chk(halt_wake, 1, "R8 wake strobe on accept");
      step(1);
      chk(halt_wake, 0, "R8 wake strobe one cycle");
      chk(cold_reset, 0, "R7 warm after pin reset");
      step(20);
      chk(core_rst, 1, "R6 held while pin low");
      ext_rst_n = 1'b1;
      step(2);
      chk(core_rst, 1, "R6 still held two edges after release");
      step(1);
      chk(core_rst, 0, "R6 released at third edge");
      step(10);

      // R5 boundary pulses
      pulse(9, saw, wakes);
      chk(saw, 0, "R5 nine-edge pulse ignored");
      chk(wakes, 0, "R8 no wake on short pulse");
      pulse(10, saw, wakes);
      chk(saw > 0, 1, "R5 ten-edge pulse accepted");
      chk(wakes, 1, "R8 single wake on ten-edge pulse");

      // R7 flag held
      step(500);
      chk(cold_reset, 0, "R7 warm flag held");

      // R5 / R8 / R7 random widths
      for (int t = 0; t < 30; t++) begin
         int w;
         w = $urandom_range(20, 1);
         prev_cold = cold_reset;
         pulse(w, saw, wakes);
         chk(saw > 0, exp_accept(w), "R5 random pulse width");
         chk(wakes, exp_accept(w) ? 1 : 0, "R8 random wake count");
         chk(cold_reset, exp_accept(w) ? 0 : prev_cold, "R7 random flag");
         step($urandom_range(12, 4));
      end

      // R9 supply dip restarts the hold
      power_down(1'b1, 2);
      supply_ok = 1'b1;
      step(2000);
      chk(core_rst, 1, "R9 held before dip");
      power_down(1'b1, 3);
      chk(cold_reset, 1, "R1 cold restored by supply loss");
      supply_ok = 1'b1;
      step(HOLD - 1);
      chk(core_rst, 1, "R9 full hold after dip");
      step(1);
      chk(core_rst, 0, "R9 release after restarted hold");

      // R10 pin reset inside the hold
      power_down(1'b1, 2);
      supply_ok = 1'b1;
      step(100);
      pulse(15, saw, wakes);
      chk(saw, 23, "R10 reset stays high across pin pulse");
      chk(cold_reset, 1, "R10 cold kept during hold");
      step(HOLD - 100 - 23 - 1);
      chk(core_rst, 1, "R10 hold not shortened");
      step(1);
      chk(core_rst, 0, "R10 hold ends on schedule");
      chk(cold_reset, 1, "R10 cold after hold");

      // R4 power-on path disabled
      power_down(1'b0, 3);
      chk(core_rst, 0, "R1 no reset in supply loss when disabled");
      chk(cold_reset, 1, "R1 cold flag when disabled");
      supply_ok = 1'b1;
      hi_cnt = 0;
      for (int i = 0; i < 200; i++) begin
         step(1);
         if (core_rst) hi_cnt++;
      end
      chk(hi_cnt, 0, "R4 no reset on supply rise when disabled");
      pulse(12, saw, wakes);
      chk(saw > 0, 1, "R4 pin still resets when disabled");
      chk(cold_reset, 0, "R7 warm after pin with path disabled");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule